// File: doc/BRIEF.md
# Camera Frame Capture Unit

This block takes the raw parallel output of a CMOS image sensor (a frame strobe, a line strobe, a pixel clock and an 8-bit sample bus) into the core clock domain, where all three strobes pass through two-flop synchronisers. A falling pixel-clock edge seen while the line strobe is high stands for one raw sample. The block frames each picture between a falling and a rising edge of the frame strobe. It counts columns and lines, and it tags every sample with its Bayer colour, taken from the parity of its row and column. The samples go into a dual-port buffer in raster order.

When a frame with the expected geometry has been stored, the block raises a done flag, and a host processor then reads the buffer through the second port. The done flag stays up until the host acknowledges it. While it is up, newly arriving frames are not captured. Each of them adds one to a drop counter, so the stored picture stays intact. A frame of the wrong shape raises an error flag instead of the done flag. The default geometry is 640 by 480. The buffer depth is a separate power-of-two parameter, and the write address wraps within it.

Top module: `cam_capture`

## Requirements
- R1: Capture of a frame starts on a falling edge of the synchronised frame strobe and ends on its next rising edge. Samples taken while no frame is being captured are not stored.
- R2: A sample is accepted only on a falling edge of the synchronised pixel clock while the synchronised line strobe is high. Pixel-clock edges with the line strobe low are ignored.
- R3: The accepted samples of a frame are stored at consecutive buffer addresses in raster order, starting at address 0 for every captured frame, with the address taken modulo BUF_DEPTH.
- R4: Each stored word is {colour[1:0], data[7:0]}. The colour code is 00 for red (even row, even column), 01 for green (even row, odd column), 10 for green (odd row, even column) and 11 for blue (odd row, odd column). Rows and columns count from 0.
- R5: A captured frame with exactly ROWS lines of exactly COLS samples sets frame_done at its end and leaves frame_err low.
- R6: A captured frame with any line of the wrong length, or with the wrong number of lines, sets frame_err and leaves frame_done low. Samples beyond COLS in a line or beyond ROWS lines are not written. frame_done and frame_err are never high together.
- R7: frame_done stays high until host_ack is pulsed. A host_ack pulse clears both frame_done and frame_err on the following cycle.
- R8: A frame that starts while frame_done is high is not captured: the buffer keeps its contents, and drop_count rises by one, saturating at its all-ones value.
- R9: host_rd_data returns the word at host_rd_addr one clock cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Sensor pixel clock, asynchronous |
| cam_href | input | 1 | Sensor line-valid strobe, asynchronous |
| cam_vsync | input | 1 | Sensor frame strobe, low during a frame |
| cam_data | input | DW | Sensor sample bus |
| host_ack | input | 1 | Host pulse that clears frame_done and frame_err |
| host_rd_addr | input | log2(BUF_DEPTH) | Host read address |
| host_rd_data | output | DW+2 | Stored word {colour, data}, one cycle after the address |
| frame_done | output | 1 | A complete frame is held in the buffer |
| frame_err | output | 1 | The last captured frame had the wrong geometry |
| drop_count | output | DROP_W | Saturating count of frames dropped while done was set |

## Verification
The bench builds the block with an 8-column, 4-row frame and a 32-word buffer. At this size a whole picture is only 32 samples, so every stored word can be read back and compared against its expected colour code and data. Short lines, missing lines and stray pixel clocks both outside lines and outside frames then cost only a few hundred cycles each. DROP_W is set to 2, so four frames arriving while done is held are enough to reach the saturation of the drop counter.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;
  typedef enum logic [1:0] {
    BAYER_R  = 2'b00,
    BAYER_GR = 2'b01,
    BAYER_GB = 2'b10,
    BAYER_B  = 2'b11
  } bayer_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAP  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d_in[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign d_out = sync_q;
endmodule

// File: rtl/cam_frame_ram.sv
module cam_frame_ram #(
  parameter int AW = 12,
  parameter int W  = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cam_framer.sv
module cam_framer
  import cam_capture_pkg::*;
#(
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int DW     = 8,
  parameter int AW     = 12,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_s,
  input  logic              href_s,
  input  logic              vsync_s,
  input  logic [DW-1:0]     data_s,
  input  logic              host_ack,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DW+1:0]     wr_word,
  output logic              frame_done,
  output logic              frame_err,
  output logic [DROP_W-1:0] drop_count
);
  localparam int COL_W = $clog2(COLS + 1);
  localparam int ROW_W = $clog2(ROWS + 1);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS);
  localparam logic [DROP_W-1:0] DROP_SAT = '1;

  cap_state_e        state_q, state_d;
  logic              pclk_q, href_q, vsync_q;
  logic [COL_W-1:0]  col_q, col_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              bad_q, bad_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DROP_W-1:0] drop_q, drop_d;

  logic pclk_fall, href_fall, vsync_fall, vsync_rise, accept;
  bayer_e colour;

  assign pclk_fall  = pclk_q & ~pclk_s;
  assign href_fall  = href_q & ~href_s;
  assign vsync_fall = vsync_q & ~vsync_s;
  assign vsync_rise = ~vsync_q & vsync_s;
  assign accept     = (state_q == ST_CAP) && pclk_fall && href_s &&
                      (col_q < COL_MAX) && (row_q < ROW_MAX);
  assign colour     = bayer_e'({row_q[0], col_q[0]});

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    addr_d  = addr_q;
    bad_d   = bad_q;
    done_d  = done_q;
    err_d   = err_q;
    drop_d  = drop_q;

    if (host_ack) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end

    if (vsync_fall) begin
      if (done_q) begin
        if (drop_q != DROP_SAT) drop_d = drop_q + 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = ST_CAP;
        col_d   = '0;
        row_d   = '0;
        addr_d  = '0;
        bad_d   = 1'b0;
      end
    end else if (state_q == ST_CAP) begin
      if (accept) begin
        addr_d = addr_q + 1'b1;
        col_d  = col_q + 1'b1;
      end else if (pclk_fall && href_s) begin
        bad_d = 1'b1;
      end
      if (href_fall) begin
        if (col_q != COL_MAX || row_q == ROW_MAX) bad_d = 1'b1;
        if (row_q != ROW_MAX) row_d = row_q + 1'b1;
        col_d = '0;
      end
      if (vsync_rise) begin
        state_d = ST_IDLE;
        if (!bad_d && row_d == ROW_MAX && col_d == '0) begin
          done_d = 1'b1;
          err_d  = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pclk_q  <= 1'b0;
      href_q  <= 1'b0;
      vsync_q <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
      addr_q  <= '0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      pclk_q  <= pclk_s;
      href_q  <= href_s;
      vsync_q <= vsync_s;
      col_q   <= col_d;
      row_q   <= row_d;
      addr_q  <= addr_d;
      bad_q   <= bad_d;
      done_q  <= done_d;
      err_q   <= err_d;
      drop_q  <= drop_d;
    end
  end

  assign wr_en      = accept;
  assign wr_addr    = addr_q;
  assign wr_word    = {colour, data_s};
  assign frame_done = done_q;
  assign frame_err  = err_q;
  assign drop_count = drop_q;

  assert_write_in_line_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (href_s && !pclk_s && state_q == ST_CAP));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !vsync_fall) |=> (wr_addr == $past(wr_addr) + 1'b1));

  assert_frame_start_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (vsync_fall && !done_q) |=> (wr_addr == '0));

  assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_err));

  assert_done_held_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !host_ack) |=> frame_done);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> (!frame_done && !frame_err));

  assert_drop_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> $past(frame_done));

  assert_no_write_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !wr_en);
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_capture_pkg::*;
#(
  parameter int COLS      = 640,
  parameter int ROWS      = 480,
  parameter int DW        = 8,
  parameter int BUF_DEPTH = 4096,
  parameter int DROP_W    = 16,
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int WORD_W   = DW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cam_pclk,
  input  logic              cam_href,
  input  logic              cam_vsync,
  input  logic [DW-1:0]     cam_data,
  input  logic              host_ack,
  input  logic [BUF_AW-1:0] host_rd_addr,
  output logic [WORD_W-1:0] host_rd_data,
  output logic              frame_done,
  output logic              frame_err,
  output logic [DROP_W-1:0] drop_count
);
  localparam int SYNC_W = DW + 3;

  logic [SYNC_W-1:0] sync_out;
  logic              wr_en;
  logic [BUF_AW-1:0] wr_addr;
  logic [WORD_W-1:0] wr_word;

  initial begin
    assert_depth_pow2_R3: assert ((1 << BUF_AW) == BUF_DEPTH);
  end

  cam_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({cam_vsync, cam_href, cam_pclk, cam_data}),
    .d_out (sync_out)
  );

  cam_framer #(
    .COLS(COLS), .ROWS(ROWS), .DW(DW), .AW(BUF_AW), .DROP_W(DROP_W)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .pclk_s     (sync_out[DW]),
    .href_s     (sync_out[DW+1]),
    .vsync_s    (sync_out[DW+2]),
    .data_s     (sync_out[DW-1:0]),
    .host_ack   (host_ack),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_word    (wr_word),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .drop_count (drop_count)
  );

  cam_frame_ram #(.AW(BUF_AW), .W(WORD_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_word),
    .rd_addr (host_rd_addr),
    .rd_data (host_rd_data)
  );
endmodule

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
  localparam int CLK_PERIOD = 12;
  localparam int COLS  = 8;
  localparam int ROWS  = 4;
  localparam int DEPTH = 32;
  localparam int DROPW = 2;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cam_pclk = 1'b0, cam_href = 1'b0, cam_vsync = 1'b1;
  logic [7:0] cam_data = '0;
  logic host_ack = 1'b0;
  logic [AW-1:0] host_rd_addr = '0;
  logic [9:0] host_rd_data;
  logic frame_done, frame_err;
  logic [DROPW-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_capture #(.COLS(COLS), .ROWS(ROWS), .DW(8), .BUF_DEPTH(DEPTH), .DROP_W(DROPW)) dut (
    .clk(clk), .rst(rst), .cam_pclk(cam_pclk), .cam_href(cam_href),
    .cam_vsync(cam_vsync), .cam_data(cam_data), .host_ack(host_ack),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .frame_done(frame_done), .frame_err(frame_err), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pixel(input logic [7:0] d);
    cam_data = d;
    cam_pclk = 1'b1;
    wait_clk(3);
    cam_pclk = 1'b0;
    wait_clk(3);
  endtask

  // Driver: one line; pushes expected words for the scoreboard when asked.
  task automatic send_line(input int n, input int row, input int seed, input bit push);
    cam_href = 1'b1;
    wait_clk(2);
    for (int c = 0; c < n; c++) begin
      logic [7:0] d;
      d = 8'((seed * 37) + (row * 16) + c * 3 + 1);
      pixel(d);
      if (push && c < COLS && row < ROWS)
        exp_q.push_back({row[0], c[0], d});   // R4 colour code {row parity, column parity}
    end
    cam_href = 1'b0;
    wait_clk(3);
    pixel(8'hFF);                              // R2 stray edge with line strobe low
    wait_clk(2);
  endtask

  task automatic send_frame(input int nrows, input int short_row, input int seed, input bit push);
    cam_vsync = 1'b0;
    wait_clk(4);
    for (int r = 0; r < nrows; r++)
      send_line((r == short_row) ? COLS - 1 : COLS, r, seed, push);
    cam_vsync = 1'b1;
    wait_clk(10);
  endtask

  // Monitor: reads the buffer and pops the expected words in address order.
  task automatic drain_and_compare(input string req);
    int a = 0;
    while (exp_q.size() > 0) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      host_rd_addr = AW'(a);
      wait_clk(1);                             // R9 one-cycle read latency
      check(host_rd_data == e, req, host_rd_data, e);
      a++;
    end
  endtask

  task automatic read_word(input int a, output logic [9:0] w);
    host_rd_addr = AW'(a);
    wait_clk(1);
    w = host_rd_data;
  endtask

  task automatic ack();
    host_ack = 1'b1;
    wait_clk(1);
    host_ack = 1'b0;
    wait_clk(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [9:0] w0, w;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    check(!frame_done && !frame_err && drop_count == 0, "reset", {frame_done, frame_err, drop_count}, 0);

    // R1: sample activity before a frame starts is ignored
    cam_href = 1'b1;
    pixel(8'h55); pixel(8'h66);
    cam_href = 1'b0;
    wait_clk(4);
    check(!frame_done && !frame_err, "R1 idle samples", {frame_done, frame_err}, 0);

    // R5: good frame; R2/R3/R4/R9 read-back
    send_frame(ROWS, -1, 1, 1'b1);
    check(frame_done == 1'b1, "R5 done after good frame", frame_done, 1);
    check(frame_err == 1'b0, "R5 no error", frame_err, 0);
    drain_and_compare("R3 R4 frame A word");
    read_word(0, w0);

    // R8: frames while done are dropped, counter saturates at 3
    for (int k = 1; k <= 4; k++) begin
      send_frame(ROWS, -1, 7 + k, 1'b0);
      check(drop_count == DROPW'((k > 3) ? 3 : k), "R8 drop count", drop_count, (k > 3) ? 3 : k);
    end
    read_word(0, w);
    check(w == w0, "R8 buffer kept", w, w0);
    check(frame_done == 1'b1, "R7 done held without ack", frame_done, 1);

    ack();
    check(frame_done == 1'b0, "R7 ack clears done", frame_done, 0);

    // R6: short line
    send_frame(ROWS, 2, 3, 1'b0);
    check(frame_err == 1'b1 && frame_done == 1'b0, "R6 short line", {frame_done, frame_err}, 1);
    ack();
    check(frame_err == 1'b0, "R7 ack clears err", frame_err, 0);

    // R6: missing line
    send_frame(ROWS - 1, -1, 4, 1'b0);
    check(frame_err == 1'b1 && frame_done == 1'b0, "R6 missing line", {frame_done, frame_err}, 1);
    ack();

    // R6: extra line (nothing written beyond the frame, address wraps otherwise)
    send_frame(ROWS + 1, -1, 5, 1'b0);
    check(frame_err == 1'b1 && frame_done == 1'b0, "R6 extra line", {frame_done, frame_err}, 1);
    ack();

    // R1/R3: a fresh good frame restarts at address 0 and overwrites all words
    send_frame(ROWS, -1, 9, 1'b1);
    check(frame_done == 1'b1 && frame_err == 1'b0, "R5 second good frame", {frame_done, frame_err}, 2);
    drain_and_compare("R3 R4 frame B word");
    ack();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule